// File: doc/BRIEF.md
# Raw NAND Flash Bus Controller

This block connects a simple 32-bit register port to an 8-bit raw NAND flash bus. Software controls the command-latch, address-latch, chip-enable and write-enable levels through a mode register. The controller turns each access to the data register into one timed flash bus cycle. When the write-enable mode bit is set, a write to the data register puts the low byte on the bus under a write strobe. A read of the data register pulses the read strobe and returns the byte captured from the bus.

A strobe-timing register sets the low time of each strobe and the time the bus stays owned after the strobe ends, both in clock cycles. The chip-enable level goes to one of up to four devices, picked by a select field. The flash ready/busy line is synchronised before it reaches a status bit. Writing a self-clearing bit returns the controller to its idle state. While a strobe or its hold time is still running, a data-register access is held off with a wait on the port's ready line. The `HOLD_ADD` parameter adds one more cycle to the hold phase.

Top module: `nfc_bus_ctrl`

## Requirements
- R1: After reset the mode register reads 0x00, the timing register reads 0xFF, status and reset registers read 0, all chip enables are high, both strobes are high, the command and address latch pins are low and the data bus is not driven.
- R2: Registers decode on byte offset: data 0x00, mode 0x04, status 0x08, timing 0x14, reset 0x18. The mode byte holds write-enable at bit 7, a stored two-bit error-code mode at bits 6:5, chip-enable at bit 4, device select at bits 3:2, address latch at bit 1 and command latch at bit 0, and it reads back as written. Offsets 0x0C and 0x10 read 0.
- R3: The command latch pin follows mode bit 0 and the address latch pin follows mode bit 1.
- R4: With mode bit 4 set, the active-low enable of the device numbered by bits 3:2 is low and all others are high. With bit 4 clear, all enables are high.
- R5: The timing register holds the hold count H at bits 7:4 and the strobe count S at bits 3:0. A data write with write-enable set drives the written byte with the write strobe low for S+1 cycles, then keeps the byte driven for H+1 more cycles (H+2 when `HOLD_ADD` is 1).
- R6: A data write while mode bit 7 is 0 is accepted at once and produces no write strobe and no bus drive.
- R7: A data read pulses the read strobe for S+1 cycles and samples the bus as the strobe ends. It completes after the hold phase, returning the byte in bits 7:0 with the upper bits zero. With the default `HOLD_ADD`, ready stays low for S+H+2 cycles after the request is presented.
- R8: A data-register access presented while a strobe or hold phase is running keeps ready low until the controller is idle. Two back-to-back writes therefore wait S+H+2 cycles on the second.
- R9: Status bit 7 reads 1 while the ready/busy input is low. A change on that input becomes visible after two clock edges.
- R10: Writing 1 to bit 0 of the reset register sets that bit for `RST_CYCLES` cycles. During that time any strobe is abandoned and the mode and timing registers return to their reset values. The bit then clears by itself.
- R11: The write and read strobes are never low together, and the data bus is never driven while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | REG_W | Write data |
| bus_ready | output | 1 | Access completes on a clock edge where request and ready are both high |
| bus_rdata | output | REG_W | Read data, valid while ready is high |
| fl_cle | output | 1 | Flash command latch enable |
| fl_ale | output | 1 | Flash address latch enable |
| fl_ce_n | output | DEV_CNT | Active-low chip enable, one per device |
| fl_we_n | output | 1 | Active-low write strobe |
| fl_re_n | output | 1 | Active-low read strobe |
| fl_dq_o | output | 8 | Flash data out |
| fl_dq_oe | output | 1 | Flash data output enable |
| fl_dq_i | input | 8 | Flash data in |
| fl_rb_n | input | 1 | Flash ready/busy, low = busy |

## Verification
The hardest case to reach is a data access that arrives during the hold phase of an earlier strobe. From the port this shows up only as a longer wait. The bench returns from one accepted write on the falling edge just after the strobe starts and presents a second write on that same edge. It then counts the low-ready cycles and compares them with S+H+2. Strobe and hold widths are checked by counting strobe-low and drive-enable cycles on the flash pins for several timing settings, including the zero and maximum counts. The soft reset is checked by reading the self-clearing bit while it is still set and again after it has cleared.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

   // byte offsets of the register port
   localparam int unsigned OFS_DATA   = 'h00;
   localparam int unsigned OFS_MODE   = 'h04;
   localparam int unsigned OFS_STAT   = 'h08;
   localparam int unsigned OFS_IRQS   = 'h0C;
   localparam int unsigned OFS_IRQM   = 'h10;
   localparam int unsigned OFS_TIMING = 'h14;
   localparam int unsigned OFS_SRST   = 'h18;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_STROBE = 2'd1,
      SEQ_HOLD   = 2'd2
   } seq_state_t;

   typedef struct packed {
      logic       wr_en;
      logic [1:0] ecc_mode;
      logic       ce_on;
      logic [1:0] dev_sel;
      logic       addr_lat;
      logic       cmd_lat;
   } mode_reg_t;

   typedef struct packed {
      logic [3:0] hold_cnt;
      logic [3:0] pulse_cnt;
   } timing_reg_t;

endpackage

// File: rtl/nfc_rb_sync.sv
module nfc_rb_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rb_n_async,
   output logic busy
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("nfc_rb_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= rb_n_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= 1'b1;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign busy = ~chain[STAGES-1];
endmodule

// File: rtl/nfc_ce_decode.sv
module nfc_ce_decode #(
   parameter int unsigned DEV_CNT = 4,
   parameter int unsigned SEL_W   = 2
) (
   input  logic             ce_on,
   input  logic [SEL_W-1:0] dev_sel,
   output logic [DEV_CNT-1:0] ce_n
);
   generate
      if (DEV_CNT > (1 << SEL_W)) begin : g_bad_cnt
         $error("nfc_ce_decode: DEV_CNT exceeds select range");
      end
      for (genvar d = 0; d < DEV_CNT; d++) begin : g_dev
         assign ce_n[d] = ~(ce_on && (dev_sel == SEL_W'(d)));
      end
   endgenerate
endmodule

// File: rtl/nfc_strobe_seq.sv
module nfc_strobe_seq
   import nfc_pkg::*;
#(
   parameter int unsigned FL_W     = 8,
   parameter int unsigned STB_W    = 4,
   parameter bit          HOLD_ADD = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort,
   input  logic             wr_go,
   input  logic             rd_go,
   input  logic [FL_W-1:0]  wr_byte,
   input  logic [STB_W-1:0] pulse_cnt,
   input  logic [STB_W-1:0] hold_cnt,
   input  logic [FL_W-1:0]  dq_i,
   output logic             idle,
   output logic             rd_done,
   output logic [FL_W-1:0]  rd_byte,
   output logic             we_n,
   output logic             re_n,
   output logic [FL_W-1:0]  dq_o,
   output logic             dq_oe
);
   localparam int unsigned CNT_W = STB_W + 1;

   seq_state_t       state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] hold_q;
   logic [CNT_W-1:0] hold_load;
   logic             is_wr;
   logic [FL_W-1:0]  byte_q;
   logic [FL_W-1:0]  rd_q;

   // hold phase length minus one, per variant
   generate
      if (HOLD_ADD) begin : g_hold_add
         assign hold_load = CNT_W'(hold_cnt) + CNT_W'(1);
      end else begin : g_hold_base
         assign hold_load = CNT_W'(hold_cnt);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SEQ_IDLE;
         cnt    <= '0;
         hold_q <= '0;
         is_wr  <= 1'b0;
         byte_q <= '0;
         rd_q   <= '0;
      end else if (abort) begin
         state <= SEQ_IDLE;
         cnt   <= '0;
         is_wr <= 1'b0;
      end else begin
         unique case (state)
            SEQ_IDLE: begin
               if (wr_go || rd_go) begin
                  state  <= SEQ_STROBE;
                  cnt    <= CNT_W'(pulse_cnt);
                  hold_q <= hold_load;
                  is_wr  <= wr_go;
                  if (wr_go) byte_q <= wr_byte;
               end
            end
            SEQ_STROBE: begin
               if (cnt == '0) begin
                  state <= SEQ_HOLD;
                  cnt   <= hold_q;
                  if (!is_wr) rd_q <= dq_i;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            SEQ_HOLD: begin
               if (cnt == '0) state <= SEQ_IDLE;
               else           cnt   <= cnt - CNT_W'(1);
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign idle    = (state == SEQ_IDLE);
   assign rd_done = (state == SEQ_HOLD) && (cnt == '0) && !is_wr;
   assign rd_byte = rd_q;
   assign we_n    = ~((state == SEQ_STROBE) && is_wr);
   assign re_n    = ~((state == SEQ_STROBE) && !is_wr);
   assign dq_oe   = is_wr && (state != SEQ_IDLE);
   assign dq_o    = byte_q;
endmodule

// File: rtl/nfc_regs.sv
module nfc_regs
   import nfc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned REG_W      = 32,
   parameter int unsigned RST_CYCLES = 4,
   parameter logic [7:0]  TIMING_RST = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic              bus_ready,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic              seq_idle,
   input  logic              seq_rd_done,
   input  logic [7:0]        seq_rd_byte,
   input  logic              rb_busy,
   output mode_reg_t         mode_q,
   output timing_reg_t       timing_q,
   output logic              soft_rst,
   output logic              wr_go,
   output logic              rd_go
);
   localparam int unsigned WA_W  = ADDR_W - 2;
   localparam int unsigned RC_W  = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES);

   logic [WA_W-1:0] wa;
   logic sel_data, sel_mode, sel_stat, sel_timing, sel_srst;
   logic acc;
   logic [RC_W-1:0] rst_cnt;

   assign wa         = bus_addr[ADDR_W-1:2];
   assign sel_data   = (wa == WA_W'(OFS_DATA   >> 2));
   assign sel_mode   = (wa == WA_W'(OFS_MODE   >> 2));
   assign sel_stat   = (wa == WA_W'(OFS_STAT   >> 2));
   assign sel_timing = (wa == WA_W'(OFS_TIMING >> 2));
   assign sel_srst   = (wa == WA_W'(OFS_SRST   >> 2));

   logic unused_bits;
   assign unused_bits = ^{bus_addr[1:0], bus_wdata[REG_W-1:8]};

   always_comb begin
      if (sel_data) bus_ready = bus_wr ? (seq_idle && !soft_rst) : seq_rd_done;
      else          bus_ready = 1'b1;
   end

   assign acc   = bus_req && bus_ready;
   assign wr_go = bus_req && bus_wr && sel_data && seq_idle && !soft_rst && mode_q.wr_en;
   assign rd_go = bus_req && !bus_wr && sel_data && seq_idle && !soft_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '0;
         timing_q <= TIMING_RST;
      end else if (soft_rst) begin
         mode_q   <= '0;
         timing_q <= TIMING_RST;
      end else if (acc && bus_wr) begin
         if (sel_mode)   mode_q   <= bus_wdata[7:0];
         if (sel_timing) timing_q <= bus_wdata[7:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soft_rst <= 1'b0;
         rst_cnt  <= '0;
      end else if (soft_rst) begin
         if (rst_cnt == '0) soft_rst <= 1'b0;
         else               rst_cnt  <= rst_cnt - RC_W'(1);
      end else if (acc && bus_wr && sel_srst && bus_wdata[0]) begin
         soft_rst <= 1'b1;
         rst_cnt  <= RC_W'(RST_CYCLES - 1);
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_data)   bus_rdata[7:0] = seq_rd_byte;
      if (sel_mode)   bus_rdata[7:0] = mode_q;
      if (sel_stat)   bus_rdata[7]   = rb_busy;
      if (sel_timing) bus_rdata[7:0] = timing_q;
      if (sel_srst)   bus_rdata[0]   = soft_rst;
   end
endmodule

// File: rtl/nfc_bus_ctrl.sv
module nfc_bus_ctrl
   import nfc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned REG_W       = 32,
   parameter int unsigned DEV_CNT     = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RST_CYCLES  = 4,
   parameter bit          HOLD_ADD    = 1'b0,
   parameter logic [7:0]  TIMING_RST  = 8'hFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_req,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic               bus_ready,
   output logic [REG_W-1:0]   bus_rdata,
   output logic               fl_cle,
   output logic               fl_ale,
   output logic [DEV_CNT-1:0] fl_ce_n,
   output logic               fl_we_n,
   output logic               fl_re_n,
   output logic [7:0]         fl_dq_o,
   output logic               fl_dq_oe,
   input  logic [7:0]         fl_dq_i,
   input  logic               fl_rb_n
);
   localparam int unsigned SEL_W = 2;

   generate
      if (ADDR_W < 5)              begin : g_bad_addr  $error("ADDR_W too small"); end
      if (REG_W < 8)               begin : g_bad_reg   $error("REG_W too small");  end
      if (DEV_CNT < 1 || DEV_CNT > 4) begin : g_bad_dev $error("DEV_CNT out of range"); end
      if (RST_CYCLES < 1)          begin : g_bad_rst   $error("RST_CYCLES must be >= 1"); end
   endgenerate

   mode_reg_t   mode_q;
   timing_reg_t timing_q;
   logic        soft_rst;
   logic        wr_go, rd_go;
   logic        seq_idle, seq_rd_done;
   logic [7:0]  seq_rd_byte;
   logic        rb_busy;

   nfc_regs #(
      .ADDR_W(ADDR_W), .REG_W(REG_W), .RST_CYCLES(RST_CYCLES), .TIMING_RST(TIMING_RST)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ready(bus_ready), .bus_rdata(bus_rdata),
      .seq_idle(seq_idle), .seq_rd_done(seq_rd_done), .seq_rd_byte(seq_rd_byte),
      .rb_busy(rb_busy), .mode_q(mode_q), .timing_q(timing_q), .soft_rst(soft_rst),
      .wr_go(wr_go), .rd_go(rd_go)
   );

   nfc_strobe_seq #(
      .FL_W(8), .STB_W(4), .HOLD_ADD(HOLD_ADD)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .abort(soft_rst),
      .wr_go(wr_go), .rd_go(rd_go), .wr_byte(bus_wdata[7:0]),
      .pulse_cnt(timing_q.pulse_cnt), .hold_cnt(timing_q.hold_cnt),
      .dq_i(fl_dq_i), .idle(seq_idle), .rd_done(seq_rd_done), .rd_byte(seq_rd_byte),
      .we_n(fl_we_n), .re_n(fl_re_n), .dq_o(fl_dq_o), .dq_oe(fl_dq_oe)
   );

   nfc_ce_decode #(
      .DEV_CNT(DEV_CNT), .SEL_W(SEL_W)
   ) ce_i (
      .ce_on(mode_q.ce_on), .dev_sel(mode_q.dev_sel), .ce_n(fl_ce_n)
   );

   nfc_rb_sync #(
      .STAGES(SYNC_STAGES)
   ) rb_i (
      .clk(clk), .rst_n(rst_n), .rb_n_async(fl_rb_n), .busy(rb_busy)
   );

   assign fl_cle = mode_q.cmd_lat;
   assign fl_ale = mode_q.addr_lat;
endmodule

// File: rtl/nfc_bus_ctrl_chk.sv
module nfc_bus_ctrl_chk #(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DEV_CNT = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_req,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_ready,
   input logic [DEV_CNT-1:0] fl_ce_n,
   input logic               fl_we_n,
   input logic               fl_re_n,
   input logic               fl_dq_oe,
   input logic [7:0]         mode_bits,
   input logic               soft_rst
);
   logic is_data;
   assign is_data = (bus_addr[ADDR_W-1:2] == '0);

   // R11: strobes mutually exclusive
   p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(!fl_we_n && !fl_re_n));

   // R11: bus not driven during a read strobe
   p_no_drive_on_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_re_n |-> !fl_dq_oe);

   // R4: at most one chip enable active
   p_ce_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~fl_ce_n));

   // R8: no data access completes while a write strobe is low
   p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && is_data && !fl_we_n) |-> !bus_ready);

   // R5: a write strobe only begins after an accepted data write
   p_we_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fl_we_n) |-> $past(bus_req && bus_wr && is_data && bus_ready));

   // R6: data write with write-enable clear makes no strobe
   p_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_wr && is_data && bus_ready && !mode_bits[7] && fl_we_n) |=> fl_we_n);

   // R10: bus quiet once the soft reset has taken hold
   p_soft_rst_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && $past(soft_rst)) |-> (fl_we_n && fl_re_n && !fl_dq_oe));
endmodule

bind nfc_bus_ctrl nfc_bus_ctrl_chk #(.ADDR_W(ADDR_W), .DEV_CNT(DEV_CNT)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_ready(bus_ready), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n),
   .fl_dq_oe(fl_dq_oe), .mode_bits(mode_q), .soft_rst(soft_rst)
);

// File: tb/nfc_bus_ctrl_tb.sv
module nfc_bus_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_ready;
   logic [31:0] bus_rdata;
   logic        fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe;
   logic [3:0]  fl_ce_n;
   logic [7:0]  fl_dq_o;
   logic [7:0]  fl_dq_i = 8'h00;
   logic        fl_rb_n = 1'b1;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   nfc_bus_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
      .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
      .fl_re_n(fl_re_n), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i),
      .fl_rb_n(fl_rb_n)
   );

   // {pulse[23:20], hold[19:16], byte[15:8], mode[7:0]}
   localparam logic [23:0] VEC [4] = '{
      {4'd0,  4'd0,  8'h3C, 8'h91},
      {4'd3,  4'd2,  8'hC3, 8'h9A},
      {4'd15, 4'd15, 8'h5A, 8'h9F},
      {4'd7,  4'd0,  8'hFF, 8'h84}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   // call on a falling edge; returns on the falling edge after completion
   task automatic xfer(input logic wr, input logic [4:0] a, input logic [31:0] d,
                       output logic [31:0] q, output int waits);
      bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d; waits = 0;
      #1;
      while (!bus_ready) begin
         @(negedge clk); #1;
         waits++;
      end
      q = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_req = 1'b0; bus_wr = 1'b0;
   endtask

   function automatic logic [3:0] exp_ce(input logic [7:0] m);
      return m[4] ? ~(4'b0001 << m[3:2]) : 4'hF;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] q;
      int w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 ce_n", {28'd0, fl_ce_n}, 32'hF);
      chk("R1 strobes/oe/cle/ale", {27'd0, fl_we_n, fl_re_n, fl_dq_oe, fl_cle, fl_ale}, 32'b11000);
      xfer(1'b0, 5'h04, 0, q, w); chk("R1 mode", q, 32'h00);
      xfer(1'b0, 5'h14, 0, q, w); chk("R1 timing", q, 32'hFF);
      xfer(1'b0, 5'h08, 0, q, w); chk("R1 status", q, 32'h00);
      xfer(1'b0, 5'h18, 0, q, w); chk("R1 reset reg", q, 32'h00);

      // R2 readback and unused offsets
      xfer(1'b1, 5'h04, 32'hFFFF_FF6B, q, w);
      xfer(1'b0, 5'h04, 0, q, w); chk("R2 mode readback", q, 32'h6B);
      xfer(1'b0, 5'h0C, 0, q, w); chk("R2 offset 0x0C", q, 32'h0);
      xfer(1'b0, 5'h10, 0, q, w); chk("R2 offset 0x10", q, 32'h0);

      // R4 chip-enable decode
      for (int d = 0; d < 4; d++) begin
         xfer(1'b1, 5'h04, 32'h10 | (d << 2), q, w);
         chk($sformatf("R4 ce_n dev%0d", d), {28'd0, fl_ce_n}, {28'd0, ~(4'b0001 << d)});
      end
      xfer(1'b1, 5'h04, 32'h0C, q, w);
      chk("R4 ce off", {28'd0, fl_ce_n}, 32'hF);

      // R5 R3 R4 R7 table walk
      foreach (VEC[i]) begin
         logic [3:0] sp, hd; logic [7:0] by, md;
         int low, tot, bad;
         logic [3:0] ce_seen; logic cle_seen, ale_seen;
         {sp, hd, by, md} = VEC[i];
         xfer(1'b1, 5'h14, {24'd0, hd, sp}, q, w);
         xfer(1'b1, 5'h04, {24'd0, md}, q, w);
         chk($sformatf("R3 cle v%0d", i), {31'd0, fl_cle}, {31'd0, md[0]});
         chk($sformatf("R3 ale v%0d", i), {31'd0, fl_ale}, {31'd0, md[1]});
         xfer(1'b1, 5'h00, {24'hABCDEF, by}, q, w);
         chk($sformatf("R5 write accept wait v%0d", i), w, 0);
         low = 0; tot = 0; bad = 0;
         ce_seen = fl_ce_n; cle_seen = fl_cle; ale_seen = fl_ale;
         while (fl_dq_oe && tot < 100) begin
            if (!fl_we_n) low++;
            if (fl_dq_o !== by) bad++;
            tot++;
            @(negedge clk);
         end
         chk($sformatf("R5 strobe low v%0d", i), low, sp + 1);
         chk($sformatf("R5 drive length v%0d", i), tot, sp + hd + 2);
         chk($sformatf("R5 data on bus v%0d", i), bad, 0);
         chk($sformatf("R4 ce during strobe v%0d", i), {28'd0, ce_seen}, {28'd0, exp_ce(md)});
         chk($sformatf("R3 latches during strobe v%0d", i), {30'd0, ale_seen, cle_seen}, {30'd0, md[1:0]});
         fl_dq_i = ~by;
         xfer(1'b0, 5'h00, 0, q, w);
         chk($sformatf("R7 read data v%0d", i), q, {24'd0, ~by});
         chk($sformatf("R7 read wait v%0d", i), w, sp + hd + 2);
      end

      // R6 write ignored when write-enable bit clear
      begin
         int seen;
         xfer(1'b1, 5'h04, 32'h10, q, w);
         xfer(1'b1, 5'h00, 32'hA5, q, w);
         chk("R6 accepted at once", w, 0);
         seen = 0;
         repeat (6) begin
            if (fl_dq_oe || !fl_we_n) seen++;
            @(negedge clk);
         end
         chk("R6 no strobe or drive", seen, 0);
      end

      // R8 back-to-back writes stall
      xfer(1'b1, 5'h14, 32'h12, q, w);
      xfer(1'b1, 5'h04, 32'h80, q, w);
      xfer(1'b1, 5'h00, 32'h11, q, w);
      xfer(1'b1, 5'h00, 32'h22, q, w);
      chk("R8 second write wait", w, 2 + 1 + 2);
      chk("R8 second byte driven", {23'd0, fl_dq_oe, fl_dq_o}, {23'd0, 1'b1, 8'h22});
      repeat (8) @(negedge clk);

      // R9 busy synchronisation
      fl_rb_n = 1'b0;
      @(negedge clk);
      xfer(1'b0, 5'h08, 0, q, w); chk("R9 busy after one edge", q, 32'h00);
      xfer(1'b0, 5'h08, 0, q, w); chk("R9 busy after two edges", q, 32'h80);
      fl_rb_n = 1'b1;
      repeat (3) @(negedge clk);
      xfer(1'b0, 5'h08, 0, q, w); chk("R9 ready again", q, 32'h00);

      // R10 soft reset
      xfer(1'b1, 5'h04, 32'h93, q, w);
      xfer(1'b1, 5'h14, 32'h35, q, w);
      xfer(1'b1, 5'h18, 32'h1, q, w);
      xfer(1'b0, 5'h18, 0, q, w); chk("R10 reset bit set", q, 32'h1);
      repeat (6) @(negedge clk);
      xfer(1'b0, 5'h18, 0, q, w); chk("R10 reset bit cleared", q, 32'h0);
      xfer(1'b0, 5'h04, 0, q, w); chk("R10 mode restored", q, 32'h00);
      xfer(1'b0, 5'h14, 0, q, w); chk("R10 timing restored", q, 32'hFF);
      chk("R10 ce released", {28'd0, fl_ce_n}, 32'hF);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule